// File: doc/BRIEF.md
# Silicon Readout Stream Parser

This block sits on one optical link of a silicon-strip trigger input. It accepts a stream of 16-bit words through a valid/ready handshake. A link word carries two bytes from the front end, and the block sorts each word into one of four kinds:

- a frame header, marked by a start-of-frame flag on the input;
- a chip-identifier word;
- a channel-address/ADC pair;
- the end-of-frame trailer.

For every pair inside a chip, the block produces one strip record. The record carries the link-segment (HDI) number from the header, the current chip identifier, the 7-bit channel address and the 8-bit ADC value, qualified by a one-cycle valid strobe.

The header is latched when it arrives and its fields stay on dedicated ports until the next header:

- the 8-bit sequencer identifier;
- three downloaded status bits;
- the no-synch flag;
- the parity-error flag;
- the 3-bit HDI number.

The trailer word 0xC0C0 raises a one-cycle end-of-event pulse. From the trailer on, every word is dropped until a new header comes in flagged as a frame start. Pairs that cannot be placed are dropped and raise a sticky format-error flag.

All outputs are registered. A word accepted at one clock edge shows its effect on the outputs directly after that edge. The input is ready on every cycle once reset has been released.

Top module: `strip_stream_parser`

## Requirements
- R1: While reset is asserted, `rec_valid`, `eoe` and `fmt_err` are 0, all header outputs are 0, and `in_ready` is 0. `in_ready` becomes 1 after the first clock edge that follows reset release.
- R2: An accepted word with `in_sof`=1 is a header, whatever its content. Its upper byte appears on `hdr_seq_id`. Its lower byte is split as follows:
  - bits 7..5 go to `hdr_dl_status`;
  - bit 4 goes to `hdr_nosync`;
  - bit 3 goes to `hdr_parity_err`;
  - bits 2..0 go to `hdr_hdi`.
  These values are held unchanged until the next header.
- R3: Inside a frame, a word whose upper byte has bit 7 set, differs from 0xC0, and whose lower byte is 0x00 is a chip word. Its upper byte becomes the current chip ID, and no record is produced.
- R4: Inside a frame and after a chip word, a word whose upper byte has bit 7 clear is a pair. The next cycle shows `rec_valid`=1 for one cycle with these fields:
  - `rec_chan` = upper byte;
  - `rec_adc` = lower byte;
  - `rec_chip` = current chip ID;
  - `rec_hdi` = latched HDI number.
- R5: Inside a frame, the word 0xC0C0 produces `eoe`=1 for exactly one cycle, with no record, and ends the frame.
- R6: After a trailer, accepted words without `in_sof` (pairs, chip words, further trailers) produce no record, no `eoe` and no change of `fmt_err`.
- R7: A pair word that arrives after a header but before any chip word of that frame is dropped (no record), and it sets `fmt_err`. `fmt_err` stays 1 until reset.
- R8: Inside a frame, a non-trailer word whose upper byte has bit 7 set but which is not a chip word (address above 0x7F) is dropped, and it sets `fmt_err`.
- R9: A cycle with `in_valid`=0 has no effect: no record and no `eoe` on the next cycle.
- R10: After reset, words without `in_sof` are dropped without any output until the first header.
- R11: A header that arrives inside a frame starts a new frame. Pairs after it need a fresh chip word, so a pair straight after it is handled as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Parser can accept a word |
| in_sof | input | 1 | Marks the word as a frame header |
| in_word | input | 16 | Input link word |
| rec_valid | output | 1 | Strip record valid strobe |
| rec_hdi | output | 3 | HDI number of the record |
| rec_chip | output | 8 | Chip ID of the record |
| rec_chan | output | 7 | Channel address of the record |
| rec_adc | output | 8 | ADC value of the record |
| eoe | output | 1 | End-of-event pulse on trailer |
| fmt_err | output | 1 | Sticky format-error flag |
| hdr_seq_id | output | 8 | Latched sequencer identifier |
| hdr_dl_status | output | 3 | Latched downloaded status bits |
| hdr_nosync | output | 1 | Latched control-link no-synch flag |
| hdr_parity_err | output | 1 | Latched control-link parity-error flag |
| hdr_hdi | output | 3 | Latched HDI number |

## Verification
The assertions check on every cycle that:
- a record or an end-of-event pulse only follows an accepted word;
- a record never comes from a word with its top bit set;
- record and trailer pulse never coincide, and the pulse never lasts two cycles;
- the format-error flag never falls outside reset;
- the header ports move only after an accepted frame-start word.

Whether the record fields carry the right chip, HDI, address and ADC values can only be shown by the bench's scenarios. The same holds for dropping words after the trailer or before the first header, and for placing a pair relative to chip and header words.

// File: rtl/strip_pkg.sv
package strip_pkg;

  typedef enum logic [1:0] {
    W_PAIR  = 2'd0,
    W_CHIP  = 2'd1,
    W_TRAIL = 2'd2,
    W_BAD   = 2'd3
  } wkind_e;

  typedef enum logic [1:0] {
    S_WAIT   = 2'd0,
    S_NOCHIP = 2'd1,
    S_CHIP   = 2'd2
  } pstate_e;

endpackage

// File: rtl/strip_word_classify.sv
module strip_word_classify #(
  parameter int                 WORD_W     = 16,
  parameter logic [WORD_W/2-1:0] TRAIL_BYTE = 8'hC0
) (
  input  logic [WORD_W-1:0] word,
  output strip_pkg::wkind_e kind
);
  localparam int BYTE_W = WORD_W / 2;

  logic [BYTE_W-1:0] hi;
  logic [BYTE_W-1:0] lo;

  assign hi = word[WORD_W-1 -: BYTE_W];
  assign lo = word[BYTE_W-1:0];

  always_comb begin
    if (hi == TRAIL_BYTE && lo == TRAIL_BYTE)
      kind = strip_pkg::W_TRAIL;
    else if (hi[BYTE_W-1] && hi != TRAIL_BYTE && lo == '0)
      kind = strip_pkg::W_CHIP;
    else if (hi[BYTE_W-1])
      kind = strip_pkg::W_BAD;
    else
      kind = strip_pkg::W_PAIR;
  end
endmodule

// File: rtl/strip_frame_ctrl.sv
module strip_frame_ctrl #(
  parameter int WORD_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic                 sof,
  input  strip_pkg::wkind_e    kind,
  input  logic [WORD_W-1:0]    word,
  output logic [WORD_W-1:0]    hdr_q,
  output logic [WORD_W/2-1:0]  chip_q,
  output logic                 emit,
  output logic                 trail,
  output logic                 err
);
  localparam int BYTE_W = WORD_W / 2;

  strip_pkg::pstate_e st_q, st_d;
  logic               hdr_en;
  logic               chip_en;

  always_comb begin
    st_d    = st_q;
    hdr_en  = 1'b0;
    chip_en = 1'b0;
    emit    = 1'b0;
    trail   = 1'b0;
    err     = 1'b0;
    if (take) begin
      if (sof) begin
        hdr_en = 1'b1;
        st_d   = strip_pkg::S_NOCHIP;
      end else if (st_q != strip_pkg::S_WAIT) begin
        case (kind)
          strip_pkg::W_TRAIL: begin
            trail = 1'b1;
            st_d  = strip_pkg::S_WAIT;
          end
          strip_pkg::W_CHIP: begin
            chip_en = 1'b1;
            st_d    = strip_pkg::S_CHIP;
          end
          strip_pkg::W_BAD: err = 1'b1;
          default: begin
            if (st_q == strip_pkg::S_CHIP) emit = 1'b1;
            else                           err  = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= strip_pkg::S_WAIT;
      hdr_q  <= '0;
      chip_q <= '0;
    end else begin
      st_q <= st_d;
      if (hdr_en)  hdr_q  <= word;
      if (chip_en) chip_q <= word[WORD_W-1 -: BYTE_W];
    end
  end
endmodule

// File: rtl/strip_record_out.sv
module strip_record_out #(
  parameter int CHAN_W = 7,
  parameter int ADC_W  = 8,
  parameter int CHIP_W = 8,
  parameter int HDI_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit,
  input  logic              trail,
  input  logic              err,
  input  logic [HDI_W-1:0]  hdi_in,
  input  logic [CHIP_W-1:0] chip_in,
  input  logic [CHAN_W-1:0] chan_in,
  input  logic [ADC_W-1:0]  adc_in,
  output logic              ready,
  output logic              rec_valid,
  output logic [HDI_W-1:0]  rec_hdi,
  output logic [CHIP_W-1:0] rec_chip,
  output logic [CHAN_W-1:0] rec_chan,
  output logic [ADC_W-1:0]  rec_adc,
  output logic              eoe,
  output logic              fmt_err
);
  logic fmt_d;

  always_comb fmt_d = fmt_err | err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready     <= 1'b0;
      rec_valid <= 1'b0;
      rec_hdi   <= '0;
      rec_chip  <= '0;
      rec_chan  <= '0;
      rec_adc   <= '0;
      eoe       <= 1'b0;
      fmt_err   <= 1'b0;
    end else begin
      ready     <= 1'b1;
      rec_valid <= emit;
      eoe       <= trail;
      fmt_err   <= fmt_d;
      if (emit) begin
        rec_hdi  <= hdi_in;
        rec_chip <= chip_in;
        rec_chan <= chan_in;
        rec_adc  <= adc_in;
      end
    end
  end
endmodule

// File: rtl/strip_stream_parser.sv
module strip_stream_parser #(
  parameter int                  WORD_W     = 16,
  parameter int                  HDI_W      = 3,
  parameter int                  DL_W       = 3,
  parameter logic [WORD_W/2-1:0] TRAIL_BYTE = 8'hC0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_sof,
  input  logic [WORD_W-1:0]    in_word,
  output logic                 rec_valid,
  output logic [HDI_W-1:0]     rec_hdi,
  output logic [WORD_W/2-1:0]  rec_chip,
  output logic [WORD_W/2-2:0]  rec_chan,
  output logic [WORD_W/2-1:0]  rec_adc,
  output logic                 eoe,
  output logic                 fmt_err,
  output logic [WORD_W/2-1:0]  hdr_seq_id,
  output logic [DL_W-1:0]      hdr_dl_status,
  output logic                 hdr_nosync,
  output logic                 hdr_parity_err,
  output logic [HDI_W-1:0]     hdr_hdi
);
  localparam int BYTE_W = WORD_W / 2;
  localparam int CHAN_W = BYTE_W - 1;
  localparam int NS_BIT = HDI_W + 1;
  localparam int PE_BIT = HDI_W;

  strip_pkg::wkind_e   kind;
  logic                take;
  logic [WORD_W-1:0]   hdr_q;
  logic [BYTE_W-1:0]   chip_q;
  logic                emit;
  logic                trail;
  logic                err;

  assign take = in_valid & in_ready;

  strip_word_classify #(.WORD_W(WORD_W), .TRAIL_BYTE(TRAIL_BYTE)) u_classify (
    .word (in_word),
    .kind (kind)
  );

  strip_frame_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take),
    .sof    (in_sof),
    .kind   (kind),
    .word   (in_word),
    .hdr_q  (hdr_q),
    .chip_q (chip_q),
    .emit   (emit),
    .trail  (trail),
    .err    (err)
  );

  strip_record_out #(
    .CHAN_W (CHAN_W),
    .ADC_W  (BYTE_W),
    .CHIP_W (BYTE_W),
    .HDI_W  (HDI_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .emit      (emit),
    .trail     (trail),
    .err       (err),
    .hdi_in    (hdr_q[HDI_W-1:0]),
    .chip_in   (chip_q),
    .chan_in   (in_word[WORD_W-2 -: CHAN_W]),
    .adc_in    (in_word[BYTE_W-1:0]),
    .ready     (in_ready),
    .rec_valid (rec_valid),
    .rec_hdi   (rec_hdi),
    .rec_chip  (rec_chip),
    .rec_chan  (rec_chan),
    .rec_adc   (rec_adc),
    .eoe       (eoe),
    .fmt_err   (fmt_err)
  );

  assign hdr_seq_id     = hdr_q[WORD_W-1 -: BYTE_W];
  assign hdr_dl_status  = hdr_q[BYTE_W-1 -: DL_W];
  assign hdr_nosync     = hdr_q[NS_BIT];
  assign hdr_parity_err = hdr_q[PE_BIT];
  assign hdr_hdi        = hdr_q[HDI_W-1:0];
endmodule

// File: rtl/strip_parser_checks.sv
module strip_parser_checks #(
  parameter int HW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_sof,
  input logic          in_msb,
  input logic          rec_valid,
  input logic          eoe,
  input logic          fmt_err,
  input logic [HW-1:0] hdr_all
);
  logic took;
  assign took = in_valid && in_ready;

  assert_rec_follows_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> $past(took));

  assert_rec_low_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> !$past(in_msb));

  assert_eoe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eoe |=> !eoe);

  assert_eoe_no_rec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(eoe && rec_valid));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(took) |-> (!rec_valid && !eoe));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> fmt_err);

  assert_hdr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(took && in_sof) |-> $stable(hdr_all));
endmodule

bind strip_stream_parser strip_parser_checks #(.HW(WORD_W)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_sof    (in_sof),
  .in_msb    (in_word[WORD_W-1]),
  .rec_valid (rec_valid),
  .eoe       (eoe),
  .fmt_err   (fmt_err),
  .hdr_all   ({hdr_seq_id, hdr_dl_status, hdr_nosync, hdr_parity_err, hdr_hdi})
);

// File: tb/strip_stream_parser_bench.sv
`timescale 1ns/1ps
module strip_stream_parser_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic        in_sof;
  logic [15:0] in_word;
  logic        rec_valid;
  logic [2:0]  rec_hdi;
  logic [7:0]  rec_chip;
  logic [6:0]  rec_chan;
  logic [7:0]  rec_adc;
  logic        eoe;
  logic        fmt_err;
  logic [7:0]  hdr_seq_id;
  logic [2:0]  hdr_dl_status;
  logic        hdr_nosync;
  logic        hdr_parity_err;
  logic [2:0]  hdr_hdi;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  strip_stream_parser u_strip_stream_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_word(in_word), .rec_valid(rec_valid),
    .rec_hdi(rec_hdi), .rec_chip(rec_chip), .rec_chan(rec_chan),
    .rec_adc(rec_adc), .eoe(eoe), .fmt_err(fmt_err),
    .hdr_seq_id(hdr_seq_id), .hdr_dl_status(hdr_dl_status),
    .hdr_nosync(hdr_nosync), .hdr_parity_err(hdr_parity_err),
    .hdr_hdi(hdr_hdi)
  );

  // Row fields: sof, valid, word, rec, chan, adc, chip, hdi, eoe, fmt_err
  localparam int NV = 16;
  localparam logic [46:0] VEC [NV] = '{
    {1'b0, 1'b1, 16'h1234, 1'b0, 7'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0}, // R10
    {1'b1, 1'b1, 16'h5A6D, 1'b0, 7'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0}, // R2
    {1'b0, 1'b1, 16'h8100, 1'b0, 7'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0}, // R3
    {1'b0, 1'b1, 16'h0322, 1'b1, 7'h03, 8'h22, 8'h81, 3'd5, 1'b0, 1'b0}, // R4
    {1'b0, 1'b0, 16'h0444, 1'b0, 7'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0}, // R9
    {1'b0, 1'b1, 16'h7FFF, 1'b1, 7'h7F, 8'hFF, 8'h81, 3'd5, 1'b0, 1'b0}, // R4
    {1'b0, 1'b1, 16'h9200, 1'b0, 7'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0}, // R3
    {1'b0, 1'b1, 16'h0000, 1'b1, 7'h00, 8'h00, 8'h92, 3'd5, 1'b0, 1'b0}, // R4
    {1'b0, 1'b1, 16'hC0C0, 1'b0, 7'h00, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0}, // R5
    {1'b0, 1'b1, 16'h0555, 1'b0, 7'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0}, // R6
    {1'b0, 1'b1, 16'h8300, 1'b0, 7'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0}, // R6
    {1'b0, 1'b1, 16'hC0C0, 1'b0, 7'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0}, // R6
    {1'b1, 1'b1, 16'h0102, 1'b0, 7'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0}, // R2
    {1'b0, 1'b1, 16'hFF00, 1'b0, 7'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0}, // R3
    {1'b0, 1'b1, 16'h0A0B, 1'b1, 7'h0A, 8'h0B, 8'hFF, 3'd2, 1'b0, 1'b0}, // R4
    {1'b0, 1'b1, 16'hC0C0, 1'b0, 7'h00, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0}  // R5
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic sof, input logic vld, input logic [15:0] w);
    in_sof   = sof;
    in_valid = vld;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_word  = 16'h0;
    repeat (2) @(negedge clk);
    chk("R1 ready in reset", 64'(in_ready), 64'd0);
    chk("R1 outputs in reset", 64'({rec_valid, eoe, fmt_err}), 64'd0);
    chk("R1 header in reset",
        64'({hdr_seq_id, hdr_dl_status, hdr_nosync, hdr_parity_err, hdr_hdi}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after release", 64'(in_ready), 64'd1);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_word = 16'h0;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      logic [46:0] v;
      v = VEC[i];
      send(v[46], v[45], v[44:29]);
      chk($sformatf("row %0d R4/R5/R6/R9/R10 rec_valid", i), 64'(rec_valid), 64'(v[28]));
      chk($sformatf("row %0d R5 eoe", i), 64'(eoe), 64'(v[1]));
      chk($sformatf("row %0d R7 fmt_err", i), 64'(fmt_err), 64'(v[0]));
      if (v[28])
        chk($sformatf("row %0d R4 record", i),
            64'({rec_chan, rec_adc, rec_chip, rec_hdi}),
            64'({v[27:21], v[20:13], v[12:5], v[4:2]}));
      if (i == 1)
        chk("R2 header 5A6D",
            64'({hdr_seq_id, hdr_dl_status, hdr_nosync, hdr_parity_err, hdr_hdi}),
            64'({8'h5A, 3'd3, 1'b0, 1'b1, 3'd5}));
    end
    chk("R2 header held after frame",
        64'({hdr_seq_id, hdr_dl_status, hdr_nosync, hdr_parity_err, hdr_hdi}),
        64'({8'h01, 3'd0, 1'b0, 1'b0, 3'd2}));

    send(1'b1, 1'b1, 16'h3390);
    chk("R2 header 3390 flags",
        64'({hdr_seq_id, hdr_dl_status, hdr_nosync, hdr_parity_err, hdr_hdi}),
        64'({8'h33, 3'd4, 1'b1, 1'b0, 3'd0}));

    // R7: pair before chip word
    do_reset();
    send(1'b1, 1'b1, 16'h0001);
    send(1'b0, 1'b1, 16'h0311);
    chk("R7 early pair dropped", 64'(rec_valid), 64'd0);
    chk("R7 early pair flags error", 64'(fmt_err), 64'd1);
    send(1'b0, 1'b1, 16'h8100);
    send(1'b0, 1'b1, 16'h0101);
    chk("R7 record after chip", 64'({rec_valid, rec_chip, rec_chan}),
        64'({1'b1, 8'h81, 7'h01}));
    chk("R7 error sticky", 64'(fmt_err), 64'd1);

    // R8: address above 0x7F
    do_reset();
    send(1'b1, 1'b1, 16'h0004);
    send(1'b0, 1'b1, 16'h8800);
    send(1'b0, 1'b1, 16'h9955);
    chk("R8 high address dropped", 64'(rec_valid), 64'd0);
    chk("R8 high address flags error", 64'(fmt_err), 64'd1);

    // R11: header inside frame restarts
    do_reset();
    send(1'b1, 1'b1, 16'h0006);
    send(1'b0, 1'b1, 16'h8100);
    send(1'b0, 1'b1, 16'h0207);
    chk("R11 pair before restart", 64'({rec_valid, rec_hdi}), 64'({1'b1, 3'd6}));
    send(1'b1, 1'b1, 16'h2203);
    send(1'b0, 1'b1, 16'h0102);
    chk("R11 pair after restart dropped", 64'(rec_valid), 64'd0);
    chk("R11 pair after restart flags error", 64'(fmt_err), 64'd1);
    chk("R11 new header hdi", 64'(hdr_hdi), 64'd3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule